// File: doc/BRIEF.md
# Barrel Shifter with Shift Control

This block is a 16-bit shifting unit driven by a 4-bit instruction. Each clock edge captures the instruction, a data word and a 4-bit shift amount from a bidirectional amount port. During the following cycle the block shifts the captured word. The result goes into an output register on the next edge. The unit can do three kinds of shift: logical shifts in either direction, arithmetic shifts to the right, and rotates in either direction.

The shift amount can come from four places:

- the amount port;
- one of two programmable 4-bit amount registers (register one and register two);
- a leading-sign counter, used for normalisation.

The normalise instructions shift the word left until its sign bit and the bit below it differ. They also present the count they used on the amount port, and two of them save that count in an amount register. A strap input can keep the amount port from ever being driven. A synchronous clear sets both amount registers and the result to zero.

Instructions are issued back to back, one per cycle. An amount register loaded by one instruction is in use for the instruction captured on the next edge.

Top module: `shift_engine`

## Requirements
- R1: `op_i`, `data_i` and `sv_i` are captured on a rising edge. The result of that instruction appears on `res_o` after the next rising edge, two edges after the inputs were presented.
- R2: Opcode 0 shifts logically right by the captured port amount, and opcode 1 shifts logically left by it. Vacated bits become 0.
- R3: Opcode 2 rotates right by the port amount, and opcode 3 rotates left by it. Bits that leave one end re-enter at the other.
- R4: Opcodes 4 and 5 shift logically right and left by register one. Opcodes 6 and 7 do the same by register two. `sv_i` has no effect on them.
- R5: Opcode 8 loads register one from the port amount, and opcode 9 loads register two. During a load the result equals the captured data unchanged.
- R6: Opcodes 10, 11 and 12 shift arithmetically right by the port amount, by register one and by register two. Vacated bits copy the original bit 15.
- R7: The leading-sign count is the number of consecutive bits, from bit 14 downward, that equal bit 15. It is 15 for 0x0000 and for 0xFFFF. Opcode 13 shifts the data logically left by this count.
- R8: Opcode 14 normalises like opcode 13 and loads the count into register one. Opcode 15 does the same but loads register two.
- R9: With `sv_hold_i` low, `sv_drv_o` is 1 during the cycle after opcodes 13 to 15 are captured, and `sv_o` then carries the leading-sign count. After any other opcode is captured, `sv_drv_o` is 0.
- R10: While `sv_hold_i` is high, `sv_drv_o` is 0 whatever the instruction.
- R11: Asynchronous reset, or `clr_i` high at an edge, sets both amount registers and `res_o` to zero.
- R12: A shift amount of zero leaves the data unchanged for logical, arithmetic and rotate shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of amount registers and result |
| op_i | input | 4 | Shift instruction |
| data_i | input | 16 | Data word to shift |
| sv_i | input | 4 | Amount port, input side |
| sv_hold_i | input | 1 | Strap; high keeps the amount port undriven |
| res_o | output | 16 | Registered shift result |
| sv_o | output | 4 | Amount port, output side (leading-sign count) |
| sv_drv_o | output | 1 | Amount port drive enable |

## Verification
The bench builds the block with the default 16-bit word and the staged log-shifter variant. With a 4-bit amount, every amount from 0 to 15 can be reached, including the saturated count of 15 that the normaliser returns for all-zero and all-one words. The directed cases cover:

- a load into an amount register followed at once by an instruction that uses it;
- a normalise-and-load feeding a register shift;
- the strap overriding the port drive;
- a clear between a load and its use.

// File: rtl/shift_engine_pkg.sv
package shift_engine_pkg;

   typedef enum logic [1:0] {
      FILL_ZERO = 2'd0,
      FILL_SIGN = 2'd1,
      FILL_WRAP = 2'd2
   } fill_e;

   typedef enum logic [1:0] {
      AMT_PORT = 2'd0,
      AMT_REG1 = 2'd1,
      AMT_REG2 = 2'd2,
      AMT_PRIO = 2'd3
   } amt_src_e;

   typedef struct packed {
      fill_e    fill;
      logic     left;
      amt_src_e src;
      logic     pass;
      logic     ld_r1;
      logic     ld_r2;
      logic     drive;
   } sh_ctl_t;

   function automatic sh_ctl_t decode_op(input logic [3:0] op);
      sh_ctl_t c;
      c.fill  = FILL_ZERO;
      c.left  = 1'b0;
      c.src   = AMT_PORT;
      c.pass  = 1'b0;
      c.ld_r1 = 1'b0;
      c.ld_r2 = 1'b0;
      c.drive = 1'b0;
      case (op)
         4'h0: ;
         4'h1: c.left = 1'b1;
         4'h2: c.fill = FILL_WRAP;
         4'h3: begin c.fill = FILL_WRAP; c.left = 1'b1; end
         4'h4: c.src = AMT_REG1;
         4'h5: begin c.src = AMT_REG1; c.left = 1'b1; end
         4'h6: c.src = AMT_REG2;
         4'h7: begin c.src = AMT_REG2; c.left = 1'b1; end
         4'h8: begin c.pass = 1'b1; c.ld_r1 = 1'b1; end
         4'h9: begin c.pass = 1'b1; c.ld_r2 = 1'b1; end
         4'hA: c.fill = FILL_SIGN;
         4'hB: begin c.fill = FILL_SIGN; c.src = AMT_REG1; end
         4'hC: begin c.fill = FILL_SIGN; c.src = AMT_REG2; end
         4'hD: begin c.left = 1'b1; c.src = AMT_PRIO; c.drive = 1'b1; end
         4'hE: begin c.left = 1'b1; c.src = AMT_PRIO; c.drive = 1'b1; c.ld_r1 = 1'b1; end
         default: begin c.left = 1'b1; c.src = AMT_PRIO; c.drive = 1'b1; c.ld_r2 = 1'b1; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sign_prio_enc.sv
module sign_prio_enc #(
   parameter int DATA_W = 16,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [AMT_W-1:0]  cnt_o
);
   // Counts bits below the sign bit that repeat it; saturates at DATA_W-1 naturally.
   always_comb begin
      logic run;
      cnt_o = '0;
      run   = 1'b1;
      for (int i = DATA_W - 2; i >= 0; i--) begin
         if (run && (data_i[i] == data_i[DATA_W-1])) cnt_o = cnt_o + AMT_W'(1);
         else run = 1'b0;
      end
   end
endmodule

// File: rtl/shift_amt_ctl.sv
module shift_amt_ctl
   import shift_engine_pkg::*;
#(
   parameter int DATA_W = 16,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  sh_ctl_t          ctl_i,
   input  logic [AMT_W-1:0] port_amt_i,
   input  logic [AMT_W-1:0] prio_cnt_i,
   output logic [AMT_W-1:0] amt_o
);
   logic [AMT_W-1:0] reg1_q, reg2_q, load_val;

   // Load source: the normalise count for normalise-and-load, else the port.
   assign load_val = (ctl_i.src == AMT_PRIO) ? prio_cnt_i : port_amt_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg1_q <= '0;
         reg2_q <= '0;
      end else if (clr_i) begin
         reg1_q <= '0;
         reg2_q <= '0;
      end else begin
         if (ctl_i.ld_r1) reg1_q <= load_val;
         if (ctl_i.ld_r2) reg2_q <= load_val;
      end
   end

   always_comb begin
      if (ctl_i.pass) amt_o = '0;
      else begin
         case (ctl_i.src)
            AMT_PORT: amt_o = port_amt_i;
            AMT_REG1: amt_o = reg1_q;
            AMT_REG2: amt_o = reg2_q;
            default:  amt_o = prio_cnt_i;
         endcase
      end
   end
endmodule

// File: rtl/shift_core.sv
module shift_core
   import shift_engine_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit LOG_STAGES = 1'b1,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  fill_e             fill_i,
   input  logic              left_i,
   output logic [DATA_W-1:0] data_o
);
   logic [DATA_W-1:0] rev_in, src_v, rshift, rev_out;

   // Left shifts reuse the right-shift path on bit-reversed data.
   for (genvar i = 0; i < DATA_W; i++) begin : g_rev
      assign rev_in[i]  = data_i[DATA_W-1-i];
      assign rev_out[i] = rshift[DATA_W-1-i];
   end

   assign src_v  = left_i ? rev_in : data_i;
   assign data_o = left_i ? rev_out : rshift;

   if (LOG_STAGES) begin : g_log
      logic [AMT_W:0][DATA_W-1:0] stg;
      logic fill_bit;
      assign fill_bit = (fill_i == FILL_SIGN) && data_i[DATA_W-1];
      assign stg[0]   = src_v;
      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         localparam int SH = 2 ** s;
         logic [SH-1:0] top_bits;
         assign top_bits   = (fill_i == FILL_WRAP) ? stg[s][SH-1:0] : {SH{fill_bit}};
         assign stg[s+1]   = amt_i[s] ? {top_bits, stg[s][DATA_W-1:SH]} : stg[s];
      end
      assign rshift = stg[AMT_W];
   end else begin : g_flat
      logic [2*DATA_W-1:0] dbl;
      always_comb begin
         dbl = {src_v, src_v} >> amt_i;
         case (fill_i)
            FILL_WRAP: rshift = dbl[DATA_W-1:0];
            FILL_SIGN: rshift = DATA_W'($signed(src_v) >>> amt_i);
            default:   rshift = src_v >> amt_i;
         endcase
      end
   end
endmodule

// File: rtl/shift_engine.sv
module shift_engine
   import shift_engine_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter bit LOG_STAGES = 1'b1,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [AMT_W-1:0]  sv_i,
   input  logic              sv_hold_i,
   output logic [DATA_W-1:0] res_o,
   output logic [AMT_W-1:0]  sv_o,
   output logic              sv_drv_o
);
   if ((DATA_W < 4) || ((DATA_W & (DATA_W - 1)) != 0)) begin : g_bad_width
      $error("shift_engine: DATA_W must be a power of two of at least 4");
   end

   logic [3:0]        op_q;
   logic [DATA_W-1:0] data_q, shifted, res_q;
   logic [AMT_W-1:0]  sv_q, prio_cnt, amt;
   sh_ctl_t           ctl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= '0;
         data_q <= '0;
         sv_q   <= '0;
      end else begin
         op_q   <= op_i;
         data_q <= data_i;
         sv_q   <= sv_i;
      end
   end

   assign ctl = decode_op(op_q);

   sign_prio_enc #(.DATA_W(DATA_W)) u_prio (
      .data_i (data_q),
      .cnt_o  (prio_cnt)
   );

   shift_amt_ctl #(.DATA_W(DATA_W)) u_amt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr_i),
      .ctl_i      (ctl),
      .port_amt_i (sv_q),
      .prio_cnt_i (prio_cnt),
      .amt_o      (amt)
   );

   shift_core #(.DATA_W(DATA_W), .LOG_STAGES(LOG_STAGES)) u_core (
      .data_i (data_q),
      .amt_i  (amt),
      .fill_i (ctl.fill),
      .left_i (ctl.left),
      .data_o (shifted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     res_q <= '0;
      else if (clr_i) res_q <= '0;
      else            res_q <= shifted;
   end

   assign res_o    = res_q;
   assign sv_o     = prio_cnt;
   assign sv_drv_o = ctl.drive && !sv_hold_i;
endmodule

// File: rtl/shift_engine_chk.sv
module shift_engine_chk #(
   parameter int DATA_W = 16,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_i,
   input logic [3:0]        op_i,
   input logic [DATA_W-1:0] data_i,
   input logic [AMT_W-1:0]  sv_i,
   input logic              sv_hold_i,
   input logic [DATA_W-1:0] res_o,
   input logic              sv_drv_o
);
   p_strap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      sv_hold_i |-> !sv_drv_o);

   p_norm_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i >= 4'hD) |=> (sv_hold_i || sv_drv_o));

   p_other_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i < 4'hD) |=> !sv_drv_o);

   p_clear_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (res_o == '0));

   p_zero_amount_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_i inside {4'h0, 4'h1, 4'h2, 4'h3, 4'hA}) && (sv_i == '0)) ##1 !clr_i
      |=> (res_o == $past(data_i, 2)));

   p_rotate_keeps_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i inside {4'h2, 4'h3}) ##1 !clr_i
      |=> ($countones(res_o) == $countones($past(data_i, 2))));
endmodule

bind shift_engine shift_engine_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_i     (clr_i),
   .op_i      (op_i),
   .data_i    (data_i),
   .sv_i      (sv_i),
   .sv_hold_i (sv_hold_i),
   .res_o     (res_o),
   .sv_drv_o  (sv_drv_o)
);

// File: tb/shift_engine_test.sv
module shift_engine_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr_i = 1'b0;
   logic [3:0]  op_i = '0;
   logic [15:0] data_i = '0;
   logic [3:0]  sv_i = '0;
   logic        sv_hold_i = 1'b0;
   logic [15:0] res_o;
   logic [3:0]  sv_o;
   logic        sv_drv_o;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   shift_engine uut (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .op_i(op_i), .data_i(data_i),
      .sv_i(sv_i), .sv_hold_i(sv_hold_i), .res_o(res_o), .sv_o(sv_o), .sv_drv_o(sv_drv_o)
   );

   // kind: 0 logical, 1 arithmetic, 2 rotate; one bit per step
   function automatic logic [15:0] m_shift(int kind, bit left, int n, logic [15:0] d);
      logic [15:0] v = d;
      logic msb = d[15];
      for (int k = 0; k < n; k++) begin
         if (left) v = (kind == 2) ? {v[14:0], v[15]} : {v[14:0], 1'b0};
         else if (kind == 2) v = {v[0], v[15:1]};
         else if (kind == 1) v = {msb, v[15:1]};
         else v = {1'b0, v[15:1]};
      end
      return v;
   endfunction

   function automatic int m_lead(logic [15:0] d);
      int c = 0;
      for (int k = 14; k >= 0; k--) begin
         if (d[k] != d[15]) break;
         c++;
      end
      return c;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   logic [15:0] r_res;
   logic [3:0]  r_svo;
   logic        r_drv;

   // drive at negedge, capture edge, sample port, load edge, sample result
   task automatic run_op(logic [3:0] op, logic [15:0] d, logic [3:0] sv);
      @(negedge clk);
      op_i = op; data_i = d; sv_i = sv;
      @(posedge clk);
      @(negedge clk);
      r_drv = sv_drv_o;
      r_svo = sv_o;
      @(posedge clk);
      @(negedge clk);
      r_res = res_o;
   endtask

   task automatic t_reset;
      check("R11 reset result", 32'(res_o), 32'h0);
      check("R11 reset drive", 32'(sv_drv_o), 32'h0);
      run_op(4'h4, 16'hA5A5, 4'h7);
      check("R11 reset reg1 zero", 32'(r_res), 32'hA5A5);
   endtask

   task automatic t_port_shifts;
      run_op(4'h0, 16'h8421, 4'd4);
      check("R1 R2 lsr port", 32'(r_res), 32'h0842);
      check("R9 no drive op0", 32'(r_drv), 32'h0);
      run_op(4'h1, 16'h8421, 4'd3);
      check("R2 lsl port", 32'(r_res), 32'h2108);
      run_op(4'h1, 16'hFFFF, 4'd15);
      check("R2 lsl 15", 32'(r_res), 32'(m_shift(0, 1, 15, 16'hFFFF)));
   endtask

   task automatic t_rotates;
      run_op(4'h2, 16'h8421, 4'd4);
      check("R3 rotr", 32'(r_res), 32'h1842);
      run_op(4'h3, 16'h8421, 4'd4);
      check("R3 rotl", 32'(r_res), 32'h4218);
      run_op(4'h3, 16'h8001, 4'd15);
      check("R3 rotl 15", 32'(r_res), 32'(m_shift(2, 1, 15, 16'h8001)));
   endtask

   task automatic t_zero_amount;
      for (int op = 0; op < 4; op++) begin
         run_op(4'(op), 16'hC3A5, 4'd0);
         check("R12 zero amount", 32'(r_res), 32'hC3A5);
      end
      run_op(4'hA, 16'h9234, 4'd0);
      check("R12 zero amount arith", 32'(r_res), 32'h9234);
   endtask

   task automatic t_reg_shifts;
      run_op(4'h8, 16'h1357, 4'd5);
      check("R5 load passes data", 32'(r_res), 32'h1357);
      run_op(4'h9, 16'h2468, 4'd9);
      check("R5 load2 passes data", 32'(r_res), 32'h2468);
      run_op(4'h4, 16'hF0F0, 4'hF);
      check("R4 lsr reg1", 32'(r_res), 32'h0787);
      check("R4 port undriven", 32'(r_drv), 32'h0);
      run_op(4'h5, 16'hF0F0, 4'h1);
      check("R4 lsl reg1", 32'(r_res), 32'h1E00);
      run_op(4'h6, 16'hF0F0, 4'h0);
      check("R4 lsr reg2", 32'(r_res), 32'h0078);
      run_op(4'h7, 16'hF0F0, 4'h3);
      check("R4 lsl reg2", 32'(r_res), 32'hE000);
   endtask

   task automatic t_arith;
      run_op(4'hA, 16'h8000, 4'd4);
      check("R6 asr port neg", 32'(r_res), 32'hF800);
      run_op(4'hA, 16'h4000, 4'd4);
      check("R6 asr port pos", 32'(r_res), 32'h0400);
      run_op(4'hB, 16'h9000, 4'd0);
      check("R6 asr reg1", 32'(r_res), 32'hFC80);
      run_op(4'hC, 16'h8000, 4'd0);
      check("R6 asr reg2", 32'(r_res), 32'hFFC0);
   endtask

   task automatic t_normalise;
      logic [15:0] pats [4] = '{16'h0030, 16'hFFF0, 16'h0000, 16'hFFFF};
      foreach (pats[k]) begin
         run_op(4'hD, pats[k], 4'd0);
         check("R7 normalise result", 32'(r_res), 32'(m_shift(0, 1, m_lead(pats[k]), pats[k])));
         check("R9 count on port", 32'(r_svo), 32'(m_lead(pats[k])));
         check("R9 port driven", 32'(r_drv), 32'h1);
      end
      check("R7 count 0x0030", 32'(m_lead(16'h0030)), 32'd9);
   endtask

   task automatic t_norm_load;
      run_op(4'hE, 16'h0030, 4'd0);
      check("R8 normalise load1 result", 32'(r_res), 32'h6000);
      run_op(4'h4, 16'hF0F0, 4'd0);
      check("R8 reg1 holds count", 32'(r_res), 32'h0078);
      run_op(4'hF, 16'h1000, 4'd0);
      check("R8 normalise load2 port", 32'(r_svo), 32'd2);
      run_op(4'h7, 16'h0101, 4'd0);
      check("R8 reg2 holds count", 32'(r_res), 32'h0404);
   endtask

   task automatic t_strap;
      sv_hold_i = 1'b1;
      run_op(4'hD, 16'h0030, 4'd0);
      check("R10 strap blocks drive", 32'(r_drv), 32'h0);
      check("R10 strap result unchanged", 32'(r_res), 32'h6000);
      sv_hold_i = 1'b0;
   endtask

   task automatic t_clear;
      run_op(4'h8, 16'h0000, 4'd6);
      run_op(4'h0, 16'hBEEF, 4'd0);
      @(negedge clk);
      clr_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr_i = 1'b0;
      check("R11 clear result", 32'(res_o), 32'h0);
      run_op(4'h4, 16'hBEEF, 4'd3);
      check("R11 clear reg1", 32'(r_res), 32'hBEEF);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_port_shifts();
      t_rotates();
      t_zero_amount();
      t_reg_shifts();
      t_arith();
      t_normalise();
      t_norm_load();
      t_strap();
      t_clear();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule